// File: doc/BRIEF.md
# Cross-Thread TLB Miss Injection Controller

This controller sits beside a two-thread core and manages address translation misses without draining either pipeline. When one thread reports a miss, the controller holds that thread and sends a handler request, carrying the missing virtual address, to the front end of the other thread. The handler enters ahead of that thread's normal instruction stream. When the helper thread reports that the handler has finished, the stalled thread is released. The two directions follow the same rule.

A handler cannot be injected into a thread that is itself waiting on one. So when both threads miss in the same cycle, or when the helper thread misses while the handler bound for it is still queued or running, the controller falls back. It withdraws any pending injection and asks each thread to trap to its own handler, passing each its own faulting address. It then waits for both threads to acknowledge. An injected handler never misses. A miss tagged as coming from handler code is therefore reported as an error and is not treated as a request. A saturating count of the fallbacks is exposed for test.

Top module: `tlb_xinj_ctrl`

## Requirements
- R1: After reset, `stall_o`, `inj_valid_o`, `self_fault_o` and `hdl_miss_err_o` are all zero and `dl_count_o` is 0.
- R2: When the controller is idle and only thread 0 reports a miss not tagged as handler code, the next cycle shows `stall_o` = 2'b01 and `inj_valid_o` = 2'b10, and `inj_va1_o` equals the missing address.
- R3: The T1 case mirrors R2. A lone miss on thread 1 gives `stall_o` = 2'b10 and `inj_valid_o` = 2'b01, and `inj_va0_o` carries the address.
- R4: An injection request stays asserted, with a stable address, until the receiving thread's `inj_ready_i` is sampled high. It is low in the cycle after that handshake.
- R5: A `hdl_done_i` pulse from the receiving thread, once its injection has been accepted, clears the stall in the next cycle. A done pulse before acceptance has no effect.
- R6: Misses on both threads in the same idle cycle give `self_fault_o` = 2'b11 in the next cycle. Each thread's own address appears on `fault_va0_o` and `fault_va1_o`, with no injection and no stall.
- R7: A miss from the receiving thread while an injection into it is pending or running is a deadlock. In the next cycle the injection is withdrawn (`inj_valid_o` = 0), `stall_o` = 0 and `self_fault_o` = 2'b11. The original thread's fault address is its first miss address, and the sibling's is its new miss address.
- R8: During the fallback, each `self_fault_o` bit falls in the cycle after that thread's `fault_ack_i`. New misses are ignored. The controller is idle again once both threads have acknowledged.
- R9: A miss with `miss_in_hdl_i` set for that thread raises that thread's bit of `hdl_miss_err_o` in the next cycle. It changes nothing else.
- R10: `dl_count_o` rises by one on each entry into the fallback and holds at its maximum, 2^CNT_W-1.
- R11: If the deadlock miss and the receiving thread's done pulse arrive in the same cycle, the deadlock wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miss_valid_i | input | 2 | Per-thread miss report (bit n = thread n) |
| miss_in_hdl_i | input | 2 | Miss comes from injected handler code |
| miss_va0_i | input | VA_W | Thread 0 miss address |
| miss_va1_i | input | VA_W | Thread 1 miss address |
| hdl_done_i | input | 2 | Handler-finished pulse from the thread that ran it |
| inj_ready_i | input | 2 | Front end of thread n accepts an injection |
| fault_ack_i | input | 2 | Thread n has taken its self-fault |
| stall_o | output | 2 | Hold thread n |
| inj_valid_o | output | 2 | Injection request into thread n |
| inj_va0_o | output | VA_W | Address for handler injected into thread 0 |
| inj_va1_o | output | VA_W | Address for handler injected into thread 1 |
| self_fault_o | output | 2 | Thread n must trap to its own handler |
| fault_va0_o | output | VA_W | Thread 0 fault address |
| fault_va1_o | output | VA_W | Thread 1 fault address |
| hdl_miss_err_o | output | 2 | Miss reported from handler code |
| dl_count_o | output | CNT_W | Saturating fallback count |

## Verification
The bench builds the controller with VA_W = 16 and CNT_W = 2, so the fallback count saturates at 3 after only a few deadlocks, and the hold check in R10 can be reached in a short run. Both deadlock windows are driven: the one with the injection still waiting on a low ready, and the one with the handler already accepted, which is also the window where the done pulse collides with the miss. Both injection directions are exercised, along with acknowledgements that arrive on different cycles.

// File: rtl/tlb_xinj_pkg.sv
package tlb_xinj_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_INJ_T1     = 2'd1,
    ST_INJ_T0     = 2'd2,
    ST_SELF_FAULT = 2'd3
  } xinj_state_e;
endpackage

// File: rtl/tlb_xinj_chan.sv
module tlb_xinj_chan #(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            cancel_i,
  input  logic            finish_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [VA_W-1:0] va_o,
  output logic            running_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      running_o <= 1'b0;
      va_o      <= '0;
    end else if (cancel_i) begin
      valid_o   <= 1'b0;
      running_o <= 1'b0;
    end else if (start_i) begin
      valid_o   <= 1'b1;
      running_o <= 1'b0;
      va_o      <= va_i;
    end else begin
      if (valid_o && ready_i) begin
        valid_o   <= 1'b0;
        running_o <= 1'b1;
      end
      if (finish_i) running_o <= 1'b0;
    end
  end

  a_r4_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !cancel_i |=> valid_o && $stable(va_o));
  a_r4_drop_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !start_i |=> !valid_o);
endmodule

// File: rtl/tlb_xinj_sat_cnt.sv
module tlb_xinj_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        count_o <= '0;
    else if (inc_i && count_o != MaxVal) count_o <= count_o + 1'b1;
  end

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == MaxVal |=> count_o == MaxVal);
  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && count_o != MaxVal |=> count_o == $past(count_o) + 1'b1);
endmodule

// File: rtl/tlb_xinj_ctrl.sv
module tlb_xinj_ctrl
  import tlb_xinj_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       miss_valid_i,
  input  logic [1:0]       miss_in_hdl_i,
  input  logic [VA_W-1:0]  miss_va0_i,
  input  logic [VA_W-1:0]  miss_va1_i,
  input  logic [1:0]       hdl_done_i,
  input  logic [1:0]       inj_ready_i,
  input  logic [1:0]       fault_ack_i,
  output logic [1:0]       stall_o,
  output logic [1:0]       inj_valid_o,
  output logic [VA_W-1:0]  inj_va0_o,
  output logic [VA_W-1:0]  inj_va1_o,
  output logic [1:0]       self_fault_o,
  output logic [VA_W-1:0]  fault_va0_o,
  output logic [VA_W-1:0]  fault_va1_o,
  output logic [1:0]       hdl_miss_err_o,
  output logic [CNT_W-1:0] dl_count_o
);
  localparam int NT = 2;

  xinj_state_e     state_q, state_d;
  logic [VA_W-1:0] miss_va [NT];
  logic [VA_W-1:0] va_q    [NT];
  logic [VA_W-1:0] inj_va  [NT];
  logic [NT-1:0]   real_miss, start_inj, finish_inj, inj_run, cap_va;
  logic [NT-1:0]   fpend_q, fpend_d;
  logic            to_fault;

  assign miss_va[0] = miss_va0_i;
  assign miss_va[1] = miss_va1_i;
  assign real_miss  = miss_valid_i & ~miss_in_hdl_i;

  // thread n stalls while its handler runs in the sibling
  assign stall_o[0] = (state_q == ST_INJ_T1);
  assign stall_o[1] = (state_q == ST_INJ_T0);

  always_comb begin
    state_d    = state_q;
    start_inj  = '0;
    finish_inj = '0;
    to_fault   = 1'b0;
    fpend_d    = fpend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (real_miss == 2'b11)  to_fault = 1'b1;
        else if (real_miss[0]) begin state_d = ST_INJ_T1; start_inj[1] = 1'b1; end
        else if (real_miss[1]) begin state_d = ST_INJ_T0; start_inj[0] = 1'b1; end
      end
      ST_INJ_T1: begin
        if (real_miss[1]) to_fault = 1'b1;
        else if (hdl_done_i[1] && inj_run[1]) begin
          state_d = ST_IDLE; finish_inj[1] = 1'b1;
        end
      end
      ST_INJ_T0: begin
        if (real_miss[0]) to_fault = 1'b1;
        else if (hdl_done_i[0] && inj_run[0]) begin
          state_d = ST_IDLE; finish_inj[0] = 1'b1;
        end
      end
      ST_SELF_FAULT: begin
        fpend_d = fpend_q & ~fault_ack_i;
        if (fpend_d == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (to_fault) begin
      state_d = ST_SELF_FAULT;
      fpend_d = '1;
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_thr
    // capture the miss address of a thread that is not already stalled
    assign cap_va[g] = real_miss[g] && (state_q != ST_SELF_FAULT) && !stall_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        va_q[g] <= '0;
      else if (cap_va[g]) va_q[g] <= miss_va[g];
    end

    tlb_xinj_chan #(.VA_W(VA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_inj[g]),
      .va_i      (miss_va[NT-1-g]),
      .cancel_i  (to_fault),
      .finish_i  (finish_inj[g]),
      .ready_i   (inj_ready_i[g]),
      .valid_o   (inj_valid_o[g]),
      .va_o      (inj_va[g]),
      .running_o (inj_run[g])
    );
  end

  assign inj_va0_o   = inj_va[0];
  assign inj_va1_o   = inj_va[1];
  assign fault_va0_o = va_q[0];
  assign fault_va1_o = va_q[1];
  assign self_fault_o = (state_q == ST_SELF_FAULT) ? fpend_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      fpend_q        <= '0;
      hdl_miss_err_o <= '0;
    end else begin
      state_q        <= state_d;
      fpend_q        <= fpend_d;
      hdl_miss_err_o <= miss_valid_i & miss_in_hdl_i;
    end
  end

  tlb_xinj_sat_cnt #(.W(CNT_W)) u_dl_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (to_fault),
    .count_o (dl_count_o)
  );

  a_r2_t0_miss_injects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && real_miss == 2'b01
    |=> stall_o == 2'b01 && inj_valid_o == 2'b10 && inj_va1_o == $past(miss_va0_i));
  a_r3_t1_miss_injects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && real_miss == 2'b10
    |=> stall_o == 2'b10 && inj_valid_o == 2'b01 && inj_va0_o == $past(miss_va1_i));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INJ_T1 && inj_run[1] && hdl_done_i[1] && !real_miss[1] |=> stall_o == 2'b00);
  a_r7_deadlock_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INJ_T1 && real_miss[1]
    |=> self_fault_o == 2'b11 && inj_valid_o == 2'b00 && stall_o == 2'b00);
  a_r7_deadlock_t0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INJ_T0 && real_miss[0]
    |=> self_fault_o == 2'b11 && inj_valid_o == 2'b00 && stall_o == 2'b00);
  a_r6_simul_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && real_miss == 2'b11
    |=> self_fault_o == 2'b11 && fault_va0_o == $past(miss_va0_i) && fault_va1_o == $past(miss_va1_i));
  a_r8_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_fault_o[0] && fault_ack_i[0] |=> !self_fault_o[0]);
  a_r9_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i[0] && miss_in_hdl_i[0] |=> hdl_miss_err_o[0]);
endmodule

// File: tb/tb_tlb_xinj_ctrl.sv
`timescale 1ns/1ps
module tb_tlb_xinj_ctrl;
  localparam int VA_W  = 16;
  localparam int CNT_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       miss_valid_i = '0, miss_in_hdl_i = '0, hdl_done_i = '0;
  logic [1:0]       inj_ready_i = '0, fault_ack_i = '0;
  logic [VA_W-1:0]  miss_va0_i = '0, miss_va1_i = '0;
  logic [1:0]       stall_o, inj_valid_o, self_fault_o, hdl_miss_err_o;
  logic [VA_W-1:0]  inj_va0_o, inj_va1_o, fault_va0_o, fault_va1_o;
  logic [CNT_W-1:0] dl_count_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tlb_xinj_ctrl #(.VA_W(VA_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_in_hdl_i(miss_in_hdl_i),
    .miss_va0_i(miss_va0_i), .miss_va1_i(miss_va1_i),
    .hdl_done_i(hdl_done_i), .inj_ready_i(inj_ready_i), .fault_ack_i(fault_ack_i),
    .stall_o(stall_o), .inj_valid_o(inj_valid_o),
    .inj_va0_o(inj_va0_o), .inj_va1_o(inj_va1_o),
    .self_fault_o(self_fault_o), .fault_va0_o(fault_va0_o), .fault_va1_o(fault_va1_o),
    .hdl_miss_err_o(hdl_miss_err_o), .dl_count_o(dl_count_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "stall", 32'(stall_o), 0);
    chk("R1", "inj_valid", 32'(inj_valid_o), 0);
    chk("R1", "self_fault", 32'(self_fault_o), 0);
    chk("R1", "err", 32'(hdl_miss_err_o), 0);
    chk("R1", "count", 32'(dl_count_o), 0);
  endtask

  task automatic t_miss_t0();
    miss_valid_i = 2'b01; miss_va0_i = 16'h1234;
    step();
    miss_valid_i = '0;
    chk("R2", "stall", 32'(stall_o), 32'h1);
    chk("R2", "inj_valid", 32'(inj_valid_o), 32'h2);
    chk("R2", "inj_va1", 32'(inj_va1_o), 32'h1234);
    step();
    chk("R4", "held valid", 32'(inj_valid_o), 32'h2);
    chk("R4", "held va", 32'(inj_va1_o), 32'h1234);
    hdl_done_i = 2'b10;   // before acceptance: ignored
    step();
    hdl_done_i = '0;
    chk("R5", "early done ignored", 32'(stall_o), 32'h1);
    inj_ready_i = 2'b10;
    step();
    inj_ready_i = '0;
    chk("R4", "valid after accept", 32'(inj_valid_o), 0);
    chk("R5", "still stalled", 32'(stall_o), 32'h1);
    hdl_done_i = 2'b10;
    step();
    hdl_done_i = '0;
    chk("R5", "released", 32'(stall_o), 0);
  endtask

  task automatic t_miss_t1();
    inj_ready_i = 2'b01;
    miss_valid_i = 2'b10; miss_va1_i = 16'hBEEF;
    step();
    miss_valid_i = '0;
    chk("R3", "stall", 32'(stall_o), 32'h2);
    chk("R3", "inj_valid", 32'(inj_valid_o), 32'h1);
    chk("R3", "inj_va0", 32'(inj_va0_o), 32'hBEEF);
    step();
    inj_ready_i = '0;
    chk("R4", "accepted", 32'(inj_valid_o), 0);
    hdl_done_i = 2'b01;
    step();
    hdl_done_i = '0;
    chk("R5", "t1 released", 32'(stall_o), 0);
  endtask

  task automatic t_simul();
    miss_valid_i = 2'b11; miss_va0_i = 16'h000A; miss_va1_i = 16'h000B;
    step();
    chk("R6", "self_fault", 32'(self_fault_o), 32'h3);
    chk("R6", "fva0", 32'(fault_va0_o), 32'hA);
    chk("R6", "fva1", 32'(fault_va1_o), 32'hB);
    chk("R6", "no stall", 32'(stall_o), 0);
    chk("R6", "no inj", 32'(inj_valid_o), 0);
    chk("R10", "count 1", 32'(dl_count_o), 1);
    miss_va0_i = 16'h0F0F; miss_va1_i = 16'h0E0E;   // misses ignored in fallback
    step();
    miss_valid_i = '0;
    chk("R8", "fault held", 32'(self_fault_o), 32'h3);
    chk("R8", "fva0 held", 32'(fault_va0_o), 32'hA);
    chk("R8", "count held", 32'(dl_count_o), 1);
    fault_ack_i = 2'b01;
    step();
    fault_ack_i = '0;
    chk("R8", "t0 acked", 32'(self_fault_o), 32'h2);
    fault_ack_i = 2'b10;
    step();
    fault_ack_i = '0;
    chk("R8", "both acked", 32'(self_fault_o), 0);
    miss_valid_i = 2'b01; miss_va0_i = 16'h5555;
    step();
    miss_valid_i = '0;
    chk("R8", "idle again", 32'(stall_o), 32'h1);
    inj_ready_i = 2'b10;
    step();
    inj_ready_i = '0;
    hdl_done_i = 2'b10;
    step();
    hdl_done_i = '0;
  endtask

  task automatic t_deadlock_pending();
    miss_valid_i = 2'b01; miss_va0_i = 16'h0111;
    step();
    miss_valid_i = 2'b10; miss_va1_i = 16'h0222;
    step();
    miss_valid_i = '0;
    chk("R7", "self_fault", 32'(self_fault_o), 32'h3);
    chk("R7", "inj cancelled", 32'(inj_valid_o), 0);
    chk("R7", "no stall", 32'(stall_o), 0);
    chk("R7", "fva0", 32'(fault_va0_o), 32'h0111);
    chk("R7", "fva1", 32'(fault_va1_o), 32'h0222);
    chk("R10", "count 2", 32'(dl_count_o), 2);
    inj_ready_i = 2'b10;   // late ready must not revive the request
    fault_ack_i = 2'b11;
    step();
    inj_ready_i = '0; fault_ack_i = '0;
    chk("R8", "joint ack", 32'(self_fault_o), 0);
    chk("R7", "no revive", 32'(inj_valid_o), 0);
  endtask

  task automatic t_deadlock_running();
    inj_ready_i = 2'b01;
    miss_valid_i = 2'b10; miss_va1_i = 16'h0333;
    step();
    miss_valid_i = '0;
    step();
    inj_ready_i = '0;
    chk("R4", "accepted", 32'(inj_valid_o), 0);
    miss_valid_i = 2'b01; miss_va0_i = 16'h0444; hdl_done_i = 2'b01;
    step();
    miss_valid_i = '0; hdl_done_i = '0;
    chk("R11", "deadlock wins", 32'(self_fault_o), 32'h3);
    chk("R7", "fva1 orig", 32'(fault_va1_o), 32'h0333);
    chk("R7", "fva0 new", 32'(fault_va0_o), 32'h0444);
    chk("R10", "count 3", 32'(dl_count_o), 3);
    fault_ack_i = 2'b11;
    step();
    fault_ack_i = '0;
  endtask

  task automatic t_saturate();
    miss_valid_i = 2'b11;
    step();
    miss_valid_i = '0;
    chk("R10", "saturated", 32'(dl_count_o), 3);
    fault_ack_i = 2'b11;
    step();
    fault_ack_i = '0;
    chk("R10", "stays max", 32'(dl_count_o), 3);
  endtask

  task automatic t_hdl_err();
    miss_valid_i = 2'b01; miss_in_hdl_i = 2'b01;
    step();
    miss_valid_i = '0; miss_in_hdl_i = '0;
    chk("R9", "err", 32'(hdl_miss_err_o), 32'h1);
    chk("R9", "no stall", 32'(stall_o), 0);
    chk("R9", "no inj", 32'(inj_valid_o), 0);
    step();
    chk("R9", "err pulse", 32'(hdl_miss_err_o), 0);
    miss_valid_i = 2'b10; miss_in_hdl_i = 2'b10;
    step();
    miss_valid_i = '0; miss_in_hdl_i = '0;
    chk("R9", "err t1", 32'(hdl_miss_err_o), 32'h2);
    chk("R9", "no fault", 32'(self_fault_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_t0();
    t_miss_t1();
    t_simul();
    t_deadlock_pending();
    t_deadlock_running();
    t_saturate();
    t_hdl_err();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule